// File: doc/BRIEF.md
# Half-Flash Converter Control Sequencer

This block holds the digital control of an 8-bit two-step converter. A coarse comparator bank resolves the upper nibble and a fine bank resolves the lower nibble. The block does not model the analog ladder or the comparators. Each bank is presented as a 15-bit thermometer input, and the coarse bank has one extra overrange comparator. The block sets whether each bank is in its zero phase or its compare phase. It decodes the two nibbles, holds the coarse result until the conversion ends, and then moves the full byte and the overflow flag into the output latch at one time.

The host side has three active-low strobes (select, write, read) and a mode strap. All three strobes are asynchronous. Each passes through a two-flop synchronizer and an edge detector before the sequencer acts on it, so every strobe edge takes effect on the third rising clock edge after it. With the strap low, a read strobe starts the conversion and an internal interval times both steps. With the strap high, the write strobe times the coarse step. The fine step then ends either at an internal timeout or at an early read, whichever comes first.

Tri-state and open-drain pins are modelled as enables. `dout_oe_o` stands for the bus driver. `rdy_pull_o` high means the ready line is pulled low, and low means it is released. The step interval is 800 ns and the recovery interval is 500 ns. Both are converted to whole clock cycles, rounding up, from the clock frequency parameter.

Top module: `hfc_ctrl`

## Requirements
- R1: With `mode_i`=0 and select low, a falling read strobe starts a conversion. The coarse bank enters compare (`hi_cmp_o`=1) and the fine bank stays in zero (`lo_cmp_o`=0).
- R2: In read-strobe mode the coarse nibble is latched one step interval after the start, and at that moment the fine bank enters compare while the coarse bank returns to zero. The conversion completes one step interval later, and `irq_n_o` stays high until then.
- R3: In read-strobe mode, `rdy_pull_o` rises after select falls. It drops at completion or when select rises.
- R4: With `mode_i`=1 and select low, a falling write strobe puts the coarse bank in compare. On the rising write strobe the coarse nibble is latched and the fine bank enters compare.
- R5: In write-read mode with no read, completion happens one step interval after the rising write strobe. Select and read may both be held low throughout (stand-alone use).
- R6: A falling read strobe while select is low and the fine bank is in compare ends the conversion at once. The fine nibble is latched at that edge and `irq_n_o` goes low.
- R7: `irq_n_o` is 1 after reset, goes 0 at completion, and returns to 1 on a rising read strobe or a rising select.
- R8: Each nibble equals the number of ones in its 15-bit thermometer input, including codes that are not monotonic. The output byte is {coarse nibble, fine nibble}, with the coarse nibble in bits 7:4.
- R9: `ovf_n_o` is 1 after reset. At each completion it becomes the inverse of the overrange comparator value captured at the coarse latch, and it changes at no other time. It is never gated by the bus enable.
- R10: `dout_oe_o` is 1 only while the synchronized select and read are both low. `dout_o` is 0 whenever the enable is 0.
- R11: After completion the coarse bank stays in zero for the recovery interval. Any start strobe that arrives inside that window is ignored.
- R12: The two banks are never in compare together. The fine bank enters compare only in the cycle right after the coarse bank was in compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 1 | Strap: 0 read-strobe mode, 1 write-read mode |
| cs_n_i | input | 1 | Asynchronous active-low select |
| wr_n_i | input | 1 | Asynchronous active-low write strobe |
| rd_n_i | input | 1 | Asynchronous active-low read strobe |
| hi_therm_i | input | 15 | Coarse bank thermometer code |
| hi_over_i | input | 1 | Coarse bank overrange comparator, 1 = above full scale |
| lo_therm_i | input | 15 | Fine bank thermometer code |
| hi_cmp_o | output | 1 | Coarse bank phase, 1 compare, 0 zero |
| lo_cmp_o | output | 1 | Fine bank phase, 1 compare, 0 zero |
| dout_o | output | 8 | Latched result, 0 when not enabled |
| dout_oe_o | output | 1 | Data bus driver enable |
| irq_n_o | output | 1 | Active-low conversion-done interrupt |
| rdy_pull_o | output | 1 | 1 pulls the open-drain ready line low |
| ovf_n_o | output | 1 | Active-low overflow flag of the last result |

## Verification
Several properties are checked on every cycle. The two banks must never be in compare together, and the fine bank may only enter compare straight after the coarse bank. The data port must read zero whenever its enable is low. The overflow flag may change only in a cycle where the interrupt is low, and the coarse bank must stay in zero for the whole recovery window after each completion. The bench scenarios cover behaviour that no per-cycle property can show. These are the nibble values decoded from random and non-monotonic codes, the exact position of completion relative to the step interval in both modes, and an early read cutting the timeout short. They also cover interrupt clearing by the read and select paths, and a start strobe during recovery being dropped.

// File: rtl/hfc_pkg.sv
// Shared types for the half-flash sequencer.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package hfc_pkg;

    // Sequencer states; bank phases are decoded from these.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RD_HI = 3'd1,
        ST_RD_LO = 3'd2,
        ST_WR_HI = 3'd3,
        ST_WR_LO = 3'd4,
        ST_REZ   = 3'd5
    } hfc_state_e;

    // Bit positions of the strobes inside the synchronizer vector.
    localparam int STB_CS    = 0;
    localparam int STB_WR    = 1;
    localparam int STB_RD    = 2;
    localparam int STB_COUNT = 3;

endpackage

// File: rtl/hfc_sync.sv
// Two-flop synchronizer with edge detection for active-low strobes.
// Does: brings W asynchronous lines into the clock domain, gives the
//       synchronized level and one-cycle fall/rise pulses.
// Assumes: lines idle high, so every flop resets to 1.
module hfc_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] fall_o,
    output logic [W-1:0] rise_o
);

    logic [W-1:0] s1_q;
    logic [W-1:0] s2_q;
    logic [W-1:0] prev_q;

    // Synchronizer chain plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q   <= '1;
            s2_q   <= '1;
            prev_q <= '1;
        end else begin
            s1_q   <= async_i;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    assign lvl_o  = s2_q;
    assign fall_o = prev_q & ~s2_q;
    assign rise_o = ~prev_q & s2_q;

endmodule

// File: rtl/hfc_therm_dec.sv
// Thermometer-to-binary decoder for one comparator bank.
// Does: counts the ones of the code, so a bubble in a non-monotonic code
//       costs at most its own weight instead of a large jump.
// Assumes: N < 2**W.
module hfc_therm_dec #(
    parameter int W = 4,
    parameter int N = (1 << W) - 1
) (
    input  logic [N-1:0] therm_i,
    output logic [W-1:0] val_o
);

    // Population count of the comparator outputs.
    always_comb begin
        val_o = '0;
        for (int i = 0; i < N; i++) begin
            val_o = val_o + W'(therm_i[i]);
        end
    end

endmodule

// File: rtl/hfc_seq.sv
// Conversion sequencer for the half-flash control.
// Does: runs the bank phases in both modes, times the step and recovery
//       intervals with one shared counter, latches the result, overflow,
//       interrupt and ready indication.
// Assumes: strobes arrive already synchronized with one-cycle edge pulses;
//          comparator outputs are settled when a latch strobe occurs.
module hfc_seq
    import hfc_pkg::*;
#(
    parameter int NIB_W    = 4,
    parameter int CONV_CYC = 100,
    parameter int REZ_CYC  = 63
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_i,
    input  logic               cs_lvl_i,
    input  logic               cs_fall_i,
    input  logic               cs_rise_i,
    input  logic               wr_fall_i,
    input  logic               wr_rise_i,
    input  logic               rd_fall_i,
    input  logic               rd_rise_i,
    input  logic [NIB_W-1:0]   hi_val_i,
    input  logic               hi_over_i,
    input  logic [NIB_W-1:0]   lo_val_i,
    output logic               hi_cmp_o,
    output logic               lo_cmp_o,
    output logic               done_o,
    output logic [2*NIB_W-1:0] result_o,
    output logic               ovf_n_o,
    output logic               irq_n_o,
    output logic               rdy_pull_o
);

    localparam int TMAX = (CONV_CYC > REZ_CYC) ? CONV_CYC : REZ_CYC;
    localparam int CW   = $clog2(TMAX + 1);
    localparam logic [CW-1:0] CONV_LAST = CW'(CONV_CYC - 1);
    localparam logic [CW-1:0] REZ_LAST  = CW'(REZ_CYC - 1);

    hfc_state_e       st_q, st_d;
    logic [CW-1:0]    cnt_q;
    logic [NIB_W-1:0] hi_hold_q;
    logic             over_hold_q;
    logic             hi_latch;
    logic             done;
    logic             timed;

    // Next-state logic and latch strobes.
    always_comb begin
        st_d     = st_q;
        hi_latch = 1'b0;
        done     = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (!cs_lvl_i && !mode_i && rd_fall_i)     st_d = ST_RD_HI;
                else if (!cs_lvl_i && mode_i && wr_fall_i) st_d = ST_WR_HI;
            end
            ST_RD_HI: if (cnt_q == CONV_LAST) begin
                hi_latch = 1'b1;
                st_d     = ST_RD_LO;
            end
            ST_RD_LO: if (cnt_q == CONV_LAST) begin
                done = 1'b1;
                st_d = ST_REZ;
            end
            ST_WR_HI: if (wr_rise_i) begin
                hi_latch = 1'b1;
                st_d     = ST_WR_LO;
            end
            ST_WR_LO: if ((rd_fall_i && !cs_lvl_i) || cnt_q == CONV_LAST) begin
                done = 1'b1;
                st_d = ST_REZ;
            end
            ST_REZ: if (cnt_q == REZ_LAST) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    assign timed = (st_q == ST_RD_HI) || (st_q == ST_RD_LO) ||
                   (st_q == ST_WR_LO) || (st_q == ST_REZ);

    // State register and interval counter, cleared on every state change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_d != st_q) cnt_q <= '0;
            else if (timed)   cnt_q <= cnt_q + 1'b1;
        end
    end

    // Coarse nibble and overrange hold until completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_hold_q   <= '0;
            over_hold_q <= 1'b0;
        end else if (hi_latch) begin
            hi_hold_q   <= hi_val_i;
            over_hold_q <= hi_over_i;
        end
    end

    // Output latch and overflow flag, updated together at completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            ovf_n_o  <= 1'b1;
        end else if (done) begin
            result_o <= {hi_hold_q, lo_val_i};
            ovf_n_o  <= ~over_hold_q;
        end
    end

    // Interrupt: set by completion, cleared by read or select rising.
    always_ff @(posedge clk) begin
        if (!rst_n)                       irq_n_o <= 1'b1;
        else if (done)                    irq_n_o <= 1'b0;
        else if (rd_rise_i || cs_rise_i)  irq_n_o <= 1'b1;
    end

    // Ready pull-down: read-strobe mode only, released at completion.
    always_ff @(posedge clk) begin
        if (!rst_n)                       rdy_pull_o <= 1'b0;
        else if (done || cs_rise_i)       rdy_pull_o <= 1'b0;
        else if (cs_fall_i && !mode_i)    rdy_pull_o <= 1'b1;
    end

    assign hi_cmp_o = (st_q == ST_RD_HI) || (st_q == ST_WR_HI);
    assign lo_cmp_o = (st_q == ST_RD_LO) || (st_q == ST_WR_LO);
    assign done_o   = done;

endmodule

// File: rtl/hfc_ctrl.sv
// Top of the half-flash converter control sequencer.
// Does: synchronizes the host strobes, decodes both comparator banks and
//       drives the sequencer; gates the result onto the modelled bus.
// Assumes: clock frequency given in whole MHz; intervals rounded up.
module hfc_ctrl
    import hfc_pkg::*;
#(
    parameter int CLK_MHZ = 125,
    parameter int CONV_NS = 800,
    parameter int REZ_NS  = 500,
    parameter int NIB_W   = 4,
    localparam int THERM_W  = (1 << NIB_W) - 1,
    localparam int DATA_W   = 2 * NIB_W,
    localparam int CONV_CYC = (CLK_MHZ * CONV_NS + 999) / 1000,
    localparam int REZ_CYC  = (CLK_MHZ * REZ_NS + 999) / 1000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_i,
    input  logic               cs_n_i,
    input  logic               wr_n_i,
    input  logic               rd_n_i,
    input  logic [THERM_W-1:0] hi_therm_i,
    input  logic               hi_over_i,
    input  logic [THERM_W-1:0] lo_therm_i,
    output logic               hi_cmp_o,
    output logic               lo_cmp_o,
    output logic [DATA_W-1:0]  dout_o,
    output logic               dout_oe_o,
    output logic               irq_n_o,
    output logic               rdy_pull_o,
    output logic               ovf_n_o
);

    logic [STB_COUNT-1:0] stb_raw, stb_lvl, stb_fall, stb_rise;
    logic [1:0][THERM_W-1:0] bank_therm;
    logic [1:0][NIB_W-1:0]   bank_val;
    logic [DATA_W-1:0]       result;
    logic                    conv_done;

    // Pack strobes in their package-defined positions.
    always_comb begin
        stb_raw         = '1;
        stb_raw[STB_CS] = cs_n_i;
        stb_raw[STB_WR] = wr_n_i;
        stb_raw[STB_RD] = rd_n_i;
    end

    hfc_sync #(.W(STB_COUNT)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (stb_raw),
        .lvl_o   (stb_lvl),
        .fall_o  (stb_fall),
        .rise_o  (stb_rise)
    );

    assign bank_therm[0] = lo_therm_i;
    assign bank_therm[1] = hi_therm_i;

    // One decoder per comparator bank (0 fine, 1 coarse).
    for (genvar b = 0; b < 2; b++) begin : g_bank
        hfc_therm_dec #(.W(NIB_W), .N(THERM_W)) u_dec (
            .therm_i (bank_therm[b]),
            .val_o   (bank_val[b])
        );
    end

    hfc_seq #(
        .NIB_W    (NIB_W),
        .CONV_CYC (CONV_CYC),
        .REZ_CYC  (REZ_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_i),
        .cs_lvl_i   (stb_lvl[STB_CS]),
        .cs_fall_i  (stb_fall[STB_CS]),
        .cs_rise_i  (stb_rise[STB_CS]),
        .wr_fall_i  (stb_fall[STB_WR]),
        .wr_rise_i  (stb_rise[STB_WR]),
        .rd_fall_i  (stb_fall[STB_RD]),
        .rd_rise_i  (stb_rise[STB_RD]),
        .hi_val_i   (bank_val[1]),
        .hi_over_i  (hi_over_i),
        .lo_val_i   (bank_val[0]),
        .hi_cmp_o   (hi_cmp_o),
        .lo_cmp_o   (lo_cmp_o),
        .done_o     (conv_done),
        .result_o   (result),
        .ovf_n_o    (ovf_n_o),
        .irq_n_o    (irq_n_o),
        .rdy_pull_o (rdy_pull_o)
    );

    // Bus driver model: enabled while select and read are both low.
    assign dout_oe_o = ~stb_lvl[STB_CS] & ~stb_lvl[STB_RD];
    assign dout_o    = dout_oe_o ? result : '0;

endmodule

// File: rtl/hfc_ctrl_chk.sv
// Property checker for hfc_ctrl, attached by bind.
// Does: checks bank exclusivity and ordering, bus masking, overflow
//       update timing and the recovery window after every completion.
// Assumes: done is the sequencer's completion strobe.
module hfc_ctrl_chk #(
    parameter int REZ_CYC = 63,
    parameter int DATA_W  = 8,
    localparam int HW = $clog2(REZ_CYC + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hi_cmp,
    input logic              lo_cmp,
    input logic [DATA_W-1:0] dout,
    input logic              dout_oe,
    input logic              irq_n,
    input logic              ovf_n,
    input logic              done
);

    logic [HW-1:0] hold_q;

    // Counts down the recovery window opened by each completion.
    always_ff @(posedge clk) begin
        if (!rst_n)              hold_q <= '0;
        else if (done)           hold_q <= HW'(REZ_CYC);
        else if (hold_q != '0)   hold_q <= hold_q - 1'b1;
    end

    assert_banks_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_cmp && lo_cmp));

    assert_fine_after_coarse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_cmp) |-> $past(hi_cmp));

    assert_bus_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> (dout == '0));

    assert_ovf_at_completion_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ovf_n) |-> !irq_n);

    assert_rezero_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q != '0) |-> !hi_cmp);

endmodule

bind hfc_ctrl hfc_ctrl_chk #(.REZ_CYC(REZ_CYC), .DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hi_cmp  (hi_cmp_o),
    .lo_cmp  (lo_cmp_o),
    .dout    (dout_o),
    .dout_oe (dout_oe_o),
    .irq_n   (irq_n_o),
    .ovf_n   (ovf_n_o),
    .done    (conv_done)
);

// File: tb/sim_hfc_ctrl.sv
// Self-checking bench for hfc_ctrl: directed corners plus seeded random codes.
module sim_hfc_ctrl;

    localparam int CLK_MHZ = 125;
    localparam int TC = (CLK_MHZ * 800 + 999) / 1000;
    localparam int TR = (CLK_MHZ * 500 + 999) / 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode = 1'b0;
    logic        cs_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        rd_n = 1'b1;
    logic [14:0] hi_therm = '0;
    logic        hi_over = 1'b0;
    logic [14:0] lo_therm = '0;
    logic        hi_cmp_o, lo_cmp_o, dout_oe_o, irq_n_o, rdy_pull_o, ovf_n_o;
    logic [7:0]  dout_o;

    int errors = 0;
    int checks = 0;
    int exp_ovf = 1;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    hfc_ctrl #(.CLK_MHZ(CLK_MHZ)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode),
        .cs_n_i     (cs_n),
        .wr_n_i     (wr_n),
        .rd_n_i     (rd_n),
        .hi_therm_i (hi_therm),
        .hi_over_i  (hi_over),
        .lo_therm_i (lo_therm),
        .hi_cmp_o   (hi_cmp_o),
        .lo_cmp_o   (lo_cmp_o),
        .dout_o     (dout_o),
        .dout_oe_o  (dout_oe_o),
        .irq_n_o    (irq_n_o),
        .rdy_pull_o (rdy_pull_o),
        .ovf_n_o    (ovf_n_o)
    );

    function automatic int ones15(input logic [14:0] t);
        int n = 0;
        for (int i = 0; i < 15; i++) n += int'(t[i]);
        return n;
    endfunction

    function automatic int exp_word(input logic [14:0] h, input logic [14:0] l);
        return ones15(h) * 16 + ones15(l);
    endfunction

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Read-strobe mode conversion (R1, R2, R3, R7, R8, R9, R10).
    task automatic rd_conv(input logic [14:0] h, input logic [14:0] l, input logic ov);
        hi_therm = h; lo_therm = l; hi_over = ov; mode = 1'b0;
        @(negedge clk); cs_n = 1'b0;
        wait_n(4);
        chk("R3 ready pulled after select", rdy_pull_o, 1);
        rd_n = 1'b0;
        wait_n(5);
        chk("R1 coarse compare", hi_cmp_o, 1);
        chk("R1 fine zero", lo_cmp_o, 0);
        wait_n(TC + 1);
        chk("R2 fine compare after step", lo_cmp_o, 1);
        chk("R12 coarse back to zero", hi_cmp_o, 0);
        wait_n(TC - 8);
        chk("R2 not complete early", irq_n_o, 1);
        chk("R9 flag held before completion", ovf_n_o, exp_ovf);
        wait_n(10);
        exp_ovf = ov ? 0 : 1;
        chk("R2 complete irq", irq_n_o, 0);
        chk("R3 ready released", rdy_pull_o, 0);
        chk("R10 bus enabled", dout_oe_o, 1);
        chk("R8 result", dout_o, exp_word(h, l));
        chk("R9 overflow", ovf_n_o, exp_ovf);
        rd_n = 1'b1;
        wait_n(4);
        chk("R7 irq cleared by read rise", irq_n_o, 1);
        chk("R10 bus disabled", dout_oe_o, 0);
        chk("R10 bus zero", dout_o, 0);
        chk("R9 flag not gated", ovf_n_o, exp_ovf);
        cs_n = 1'b1;
        wait_n(TR + 10);
    endtask

    // Write-read mode conversion, optionally with an early read (R4-R9).
    task automatic wr_conv(input logic [14:0] h, input logic [14:0] l, input logic ov,
                           input bit early);
        hi_therm = h; lo_therm = l; hi_over = ov; mode = 1'b1;
        @(negedge clk); cs_n = 1'b0; wr_n = 1'b0;
        wait_n(6);
        chk("R4 coarse compare on write", hi_cmp_o, 1);
        chk("R4 fine zero during write", lo_cmp_o, 0);
        wait_n(10);
        wr_n = 1'b1;
        wait_n(6);
        chk("R4 fine compare after write rise", lo_cmp_o, 1);
        chk("R4 coarse zero after write rise", hi_cmp_o, 0);
        chk("R9 flag held before completion", ovf_n_o, exp_ovf);
        if (early) begin
            wait_n(14);
            chk("R6 pending before early read", irq_n_o, 1);
            rd_n = 1'b0;
            wait_n(5);
            chk("R6 early read completes", irq_n_o, 0);
            chk("R6 fine bank left compare", lo_cmp_o, 0);
        end else begin
            wait_n(TC - 16);
            chk("R5 not complete before timeout", irq_n_o, 1);
            wait_n(18);
            chk("R5 complete at timeout", irq_n_o, 0);
            rd_n = 1'b0;
            wait_n(4);
        end
        exp_ovf = ov ? 0 : 1;
        chk("R10 bus enabled", dout_oe_o, 1);
        chk("R8 result", dout_o, exp_word(h, l));
        chk("R9 overflow", ovf_n_o, exp_ovf);
        rd_n = 1'b1;
        wait_n(4);
        chk("R7 irq cleared by read rise", irq_n_o, 1);
        cs_n = 1'b1;
        wait_n(TR + 10);
    endtask

    // Stand-alone operation with start held off during recovery (R5, R11).
    task automatic standalone(input logic [14:0] h1, input logic [14:0] h2, input logic [14:0] l);
        mode = 1'b1; hi_therm = h1; lo_therm = l; hi_over = 1'b0;
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
        wait_n(4);
        wr_n = 1'b0; wait_n(10); wr_n = 1'b1;
        wait_n(TC + 8);
        exp_ovf = 1;
        chk("R5 stand-alone completes", irq_n_o, 0);
        chk("R10 bus enabled stand-alone", dout_oe_o, 1);
        chk("R8 stand-alone result", dout_o, exp_word(h1, l));
        hi_therm = h2;
        wr_n = 1'b0;
        wait_n(10);
        chk("R11 start ignored in recovery", hi_cmp_o, 0);
        chk("R11 fine bank idle in recovery", lo_cmp_o, 0);
        wr_n = 1'b1;
        wait_n(TC + 10);
        chk("R11 result unchanged", dout_o, exp_word(h1, l));
        wait_n(TR);
        wr_n = 1'b0; wait_n(6);
        chk("R4 start accepted after recovery", hi_cmp_o, 1);
        wait_n(4); wr_n = 1'b1;
        wait_n(TC + 8);
        chk("R8 second stand-alone result", dout_o, exp_word(h2, l));
        cs_n = 1'b1;
        wait_n(4);
        chk("R7 irq cleared by select rise", irq_n_o, 1);
        chk("R10 bus off with select high", dout_oe_o, 0);
        rd_n = 1'b1;
        wait_n(TR + 10);
    endtask

    initial begin
        logic [14:0] h, l;
        logic ov;
        void'($urandom(32'd20250611));
        wait_n(5);
        rst_n = 1'b1;
        wait_n(3);
        chk("R7 irq reset high", irq_n_o, 1);
        chk("R9 flag reset high", ovf_n_o, 1);
        chk("R3 ready reset released", rdy_pull_o, 0);
        chk("R10 bus reset off", dout_oe_o, 0);
        chk("R12 banks reset zero", {hi_cmp_o, lo_cmp_o}, 0);

        // Directed corners: empty, full, overrange.
        rd_conv(15'h0000, 15'h0000, 1'b0);
        rd_conv(15'h7fff, 15'h7fff, 1'b1);
        wr_conv(15'h00ff, 15'h0007, 1'b0, 1'b0);
        wr_conv(15'h7fff, 15'h0000, 1'b1, 1'b1);
        // Non-monotonic codes.
        rd_conv(15'h5a5a, 15'h0f0f, 1'b0);
        standalone(15'h003f, 15'h1fff, 15'h0101);

        for (int k = 0; k < 6; k++) begin
            h = 15'($urandom); l = 15'($urandom); ov = 1'($urandom);
            rd_conv(h, l, ov);
        end
        for (int k = 0; k < 6; k++) begin
            h = 15'($urandom); l = 15'($urandom); ov = 1'($urandom);
            wr_conv(h, l, ov, 1'($urandom));
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run is one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule